// File: doc/BRIEF.md
# Out-of-Order Reservation Station Pool

This block is a shared pool of waiting slots for decoded micro-operations in an out-of-order core. Each accepted operation carries an opcode, a target execution unit, a destination tag, and two source operands. Each operand is either already a value or a tag still being computed. While an operation waits, its slot watches a result broadcast bus. When a broadcast tag equals a pending source tag, the slot takes the value.

Every execution unit has its own issue port. In each cycle the pool offers that unit the oldest slot whose operands are both present and whose target is that unit, and frees the slot when the unit takes it. Later arrivals therefore pass earlier ones that are still waiting. A flush input removes every operation whose destination tag is younger than a given tag.

Dispatch and issue use valid/ready handshakes. Dispatch is accepted only while `disp_ready` is high, which means at least one free slot. An issue port holds `iss_valid` whenever it has a candidate, without regard to `iss_ready`. The offer may change before it is taken if an older slot becomes ready. The broadcast bus and flush have no back-pressure.

Top module: `rs_pool`

## Requirements
- R1: After reset the pool is empty: `disp_ready` is 1 and every `iss_valid` bit is 0. `disp_ready` is 1 exactly when a slot is free. A dispatch is stored only on a clock edge where both `disp_valid` and `disp_ready` are 1, and a dispatch offered while the pool is full is never stored.
- R2: A slot with both operands present is offered on port `disp_unit` (unit index u drives bit u of `iss_valid`), even if older slots are still waiting. The offer shows its opcode, operand A, operand B and destination tag.
- R3: On an edge where `bc_valid` is 1, every stored operand still pending on tag `bc_tag` takes `bc_data` and becomes present. The slot can be offered from the next cycle on.
- R4: A dispatched operand marked pending whose tag equals `bc_tag` while `bc_valid` is 1 in the same cycle is stored as present with `bc_data`.
- R5: Among the ready slots for one unit, the one dispatched earliest is offered.
- R6: A slot is freed on the edge where its port has `iss_valid` and `iss_ready` both at 1, and it is never offered again.
- R7: On an edge with `flush_valid` at 1, every stored slot whose destination tag is greater than `flush_tag` (unsigned compare, larger is younger) is removed. A dispatch in that cycle with such a tag is dropped.
- R8: While `iss_ready` of a unit is 0, its offered slot stays in the pool and stays offered unless an older slot for that unit becomes ready.
- R9: Units issue independently, and different units can each take one slot on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A free slot exists |
| disp_unit | input | FU_W | Target execution unit index |
| disp_op | input | OP_W | Opcode |
| disp_tag_a | input | TAG_W | Operand A producer tag |
| disp_rdy_a | input | 1 | Operand A value present |
| disp_val_a | input | DATA_W | Operand A value |
| disp_tag_b | input | TAG_W | Operand B producer tag |
| disp_rdy_b | input | 1 | Operand B value present |
| disp_val_b | input | DATA_W | Operand B value |
| disp_dst | input | TAG_W | Destination tag |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast tag |
| bc_data | input | DATA_W | Broadcast value |
| flush_valid | input | 1 | Flush request |
| flush_tag | input | TAG_W | Slots with a larger destination tag are removed |
| iss_valid | output | NUM_FU | Per-unit issue offer |
| iss_ready | input | NUM_FU | Per-unit free (not busy) |
| iss_op | output | NUM_FU x OP_W | Offered opcode per unit |
| iss_val_a | output | NUM_FU x DATA_W | Offered operand A per unit |
| iss_val_b | output | NUM_FU x DATA_W | Offered operand B per unit |
| iss_dst | output | NUM_FU x TAG_W | Offered destination tag per unit |

## Verification
A slot that misses a broadcast never becomes ready. It then fails to appear on its issue port in the cycle after the broadcast and can block the rest of the drain, so the fault is seen one cycle later. A bad age order shows as the wrong destination tag on the first offer after several slots become ready together. A slot that is not freed or not flushed shows up again as an extra offer, or as a `disp_ready` level that is wrong, one cycle after the edge in question.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // default geometry of the pool
  localparam int DEF_ENTRIES = 20;
  localparam int DEF_UNITS   = 2;
  localparam int DEF_TAG_W   = 6;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_OP_W    = 4;

  // width of a unit index, never zero
  function automatic int unit_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int FU_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [FU_W-1:0]   in_unit,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_tag_a,
  input  logic              in_rdy_a,
  input  logic [DATA_W-1:0] in_val_a,
  input  logic [TAG_W-1:0]  in_tag_b,
  input  logic              in_rdy_b,
  input  logic [DATA_W-1:0] in_val_b,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic              grant,
  output logic              busy,
  output logic              ready,
  output logic [FU_W-1:0]   unit,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b,
  output logic [TAG_W-1:0]  dst
);
  logic              have_a, have_b;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic              kill, in_dead, hit_a_in, hit_b_in;

  assign kill     = busy && flush_valid && (dst > flush_tag);
  assign in_dead  = flush_valid && (in_dst > flush_tag);
  assign hit_a_in = !in_rdy_a && bc_valid && (in_tag_a == bc_tag);
  assign hit_b_in = !in_rdy_b && bc_valid && (in_tag_b == bc_tag);
  assign ready    = busy && have_a && have_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      have_a <= 1'b0;
      have_b <= 1'b0;
      unit   <= '0;
      op     <= '0;
      tag_a  <= '0;
      tag_b  <= '0;
      val_a  <= '0;
      val_b  <= '0;
      dst    <= '0;
    end else if (busy) begin
      if (kill || grant) begin
        busy <= 1'b0;
      end else begin
        if (!have_a && bc_valid && tag_a == bc_tag) begin
          have_a <= 1'b1;
          val_a  <= bc_data;
        end
        if (!have_b && bc_valid && tag_b == bc_tag) begin
          have_b <= 1'b1;
          val_b  <= bc_data;
        end
      end
    end else if (alloc && !in_dead) begin
      busy   <= 1'b1;
      unit   <= in_unit;
      op     <= in_op;
      tag_a  <= in_tag_a;
      tag_b  <= in_tag_b;
      dst    <= in_dst;
      have_a <= in_rdy_a || hit_a_in;
      have_b <= in_rdy_b || hit_b_in;
      val_a  <= hit_a_in ? bc_data : in_val_a;
      val_b  <= hit_b_in ? bc_data : in_val_b;
    end
  end

  // R1: the allocator only writes a free slot
  p_alloc_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy);

  // R3: a captured operand keeps its value until the slot leaves
  p_hold_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && have_a && !grant && !kill) |=> (have_a && $stable(val_a)));
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int ENTRIES = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              alloc,
  output logic [ENTRIES-1:0][ENTRIES-1:0] older   // older[j][i]: j came before i
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int r = 0; r < ENTRIES; r++) begin
        for (int c = 0; c < ENTRIES; c++) begin
          if (alloc[c])      older[r][c] <= (r != c);
          else if (alloc[r]) older[r][c] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int ENTRIES = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              cand,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
  output logic [ENTRIES-1:0]              pick
);
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < ENTRIES; j++)
        beaten |= cand[j] && older[j][i];
      pick[i] = cand[i] && !beaten;
    end
  end

  // R5: at most one slot offered per unit
  p_single_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R2: a ready candidate always yields an offer
  p_offer_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> (|pick));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int NUM_FU  = DEF_UNITS,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int OP_W    = DEF_OP_W,
  localparam int FU_W   = unit_w(NUM_FU)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           disp_valid,
  output logic                           disp_ready,
  input  logic [FU_W-1:0]                disp_unit,
  input  logic [OP_W-1:0]                disp_op,
  input  logic [TAG_W-1:0]               disp_tag_a,
  input  logic                           disp_rdy_a,
  input  logic [DATA_W-1:0]              disp_val_a,
  input  logic [TAG_W-1:0]               disp_tag_b,
  input  logic                           disp_rdy_b,
  input  logic [DATA_W-1:0]              disp_val_b,
  input  logic [TAG_W-1:0]               disp_dst,
  input  logic                           bc_valid,
  input  logic [TAG_W-1:0]               bc_tag,
  input  logic [DATA_W-1:0]              bc_data,
  input  logic                           flush_valid,
  input  logic [TAG_W-1:0]               flush_tag,
  output logic [NUM_FU-1:0]              iss_valid,
  input  logic [NUM_FU-1:0]              iss_ready,
  output logic [NUM_FU-1:0][OP_W-1:0]    iss_op,
  output logic [NUM_FU-1:0][DATA_W-1:0]  iss_val_a,
  output logic [NUM_FU-1:0][DATA_W-1:0]  iss_val_b,
  output logic [NUM_FU-1:0][TAG_W-1:0]   iss_dst
);
  logic [ENTRIES-1:0]              busy, rdy, take, alloc_oh;
  logic [ENTRIES-1:0][FU_W-1:0]    s_unit;
  logic [ENTRIES-1:0][OP_W-1:0]    s_op;
  logic [ENTRIES-1:0][DATA_W-1:0]  s_a, s_b;
  logic [ENTRIES-1:0][TAG_W-1:0]   s_dst;
  logic [ENTRIES-1:0][ENTRIES-1:0] older;
  logic [NUM_FU-1:0][ENTRIES-1:0]  cand, pick;

  // lowest free slot receives the dispatch
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!busy[i] && !found) begin
        alloc_oh[i] = disp_valid;
        found       = 1'b1;
      end
    end
    disp_ready = found;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .FU_W(FU_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_oh[i]),
      .in_unit(disp_unit), .in_op(disp_op),
      .in_tag_a(disp_tag_a), .in_rdy_a(disp_rdy_a), .in_val_a(disp_val_a),
      .in_tag_b(disp_tag_b), .in_rdy_b(disp_rdy_b), .in_val_b(disp_val_b),
      .in_dst(disp_dst), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .flush_valid(flush_valid), .flush_tag(flush_tag), .grant(take[i]),
      .busy(busy[i]), .ready(rdy[i]), .unit(s_unit[i]), .op(s_op[i]),
      .val_a(s_a[i]), .val_b(s_b[i]), .dst(s_dst[i])
    );
  end

  rs_age #(.ENTRIES(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_oh & ~busy), .older(older)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    always_comb begin
      for (int i = 0; i < ENTRIES; i++)
        cand[u][i] = rdy[i] && (s_unit[i] == FU_W'(u));
    end

    rs_select #(.ENTRIES(ENTRIES)) u_sel (
      .clk(clk), .rst_n(rst_n), .cand(cand[u]), .older(older), .pick(pick[u])
    );

    always_comb begin
      iss_valid[u] = |pick[u];
      iss_op[u]    = '0;
      iss_val_a[u] = '0;
      iss_val_b[u] = '0;
      iss_dst[u]   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (pick[u][i]) begin
          iss_op[u]    = s_op[i];
          iss_val_a[u] = s_a[i];
          iss_val_b[u] = s_b[i];
          iss_dst[u]   = s_dst[i];
        end
      end
    end
  end

  always_comb begin
    take = '0;
    for (int u = 0; u < NUM_FU; u++)
      take |= pick[u] & {ENTRIES{iss_ready[u]}};
  end
endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
  localparam int ENT = 20;
  localparam int NFU = 2;
  localparam int TW  = 6;
  localparam int DW  = 16;
  localparam int OW  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, disp_valid, disp_ready, disp_rdy_a, disp_rdy_b;
  logic [0:0] disp_unit;
  logic [OW-1:0] disp_op;
  logic [TW-1:0] disp_tag_a, disp_tag_b, disp_dst, bc_tag, flush_tag;
  logic [DW-1:0] disp_val_a, disp_val_b, bc_data;
  logic bc_valid, flush_valid;
  logic [NFU-1:0] iss_valid, iss_ready;
  logic [NFU-1:0][OW-1:0] iss_op;
  logic [NFU-1:0][DW-1:0] iss_val_a, iss_val_b;
  logic [NFU-1:0][TW-1:0] iss_dst;

  rs_pool #(.ENTRIES(ENT), .NUM_FU(NFU), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_unit(disp_unit), .disp_op(disp_op),
    .disp_tag_a(disp_tag_a), .disp_rdy_a(disp_rdy_a), .disp_val_a(disp_val_a),
    .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b), .disp_val_b(disp_val_b),
    .disp_dst(disp_dst), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_val_a(iss_val_a), .iss_val_b(iss_val_b), .iss_dst(iss_dst)
  );

  typedef struct packed {
    logic          dv;
    logic [0:0]    du;
    logic [TW-1:0] dst;
    logic [TW-1:0] ta;
    logic          va;
    logic [DW-1:0] da;
    logic [TW-1:0] tb;
    logic          vb;
    logic [DW-1:0] db;
    logic          bv;
    logic [TW-1:0] bt;
    logic [DW-1:0] bd;
    logic [1:0]    rdy;
    logic [1:0]    eiv;
    logic [TW-1:0] e0d;
    logic [DW-1:0] e0a;
    logic [DW-1:0] e0b;
    logic [TW-1:0] e1d;
    logic [DW-1:0] e1a;
    logic [DW-1:0] e1b;
  } vec_t;

  localparam int NV = 11;
  // outputs checked reflect all earlier rows; this row's inputs act at the next edge
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,6'd1, 6'd0,1'b1,16'd10, 6'd9,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b00, 2'b00, 6'd0,16'd0,16'd0,  6'd0,16'd0,16'd0}, // A waits on tag 9
    '{1'b1,1'b0,6'd2, 6'd0,1'b1,16'd20, 6'd0,1'b1,16'd21, 1'b0,6'd0,16'd0,  2'b00, 2'b00, 6'd0,16'd0,16'd0,  6'd0,16'd0,16'd0}, // R1 B ready
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b00, 2'b01, 6'd2,16'd20,16'd21, 6'd0,16'd0,16'd0}, // R2 B passes A
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b1,6'd9,16'd99, 2'b00, 2'b01, 6'd2,16'd20,16'd21, 6'd0,16'd0,16'd0}, // R8 held, bcast 9
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b01, 2'b01, 6'd1,16'd10,16'd99, 6'd0,16'd0,16'd0}, // R3 R5 A older
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b01, 2'b01, 6'd2,16'd20,16'd21, 6'd0,16'd0,16'd0}, // R6 then B
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b00, 2'b00, 6'd0,16'd0,16'd0,  6'd0,16'd0,16'd0}, // R6 empty
    '{1'b1,1'b1,6'd3, 6'd12,1'b0,16'd0, 6'd0,1'b1,16'd5,  1'b1,6'd12,16'd7, 2'b00, 2'b00, 6'd0,16'd0,16'd0,  6'd0,16'd0,16'd0}, // R4 same-cycle
    '{1'b1,1'b0,6'd4, 6'd0,1'b1,16'd1,  6'd0,1'b1,16'd2,  1'b0,6'd0,16'd0,  2'b00, 2'b10, 6'd0,16'd0,16'd0,  6'd3,16'd7,16'd5},  // R4 C on unit 1
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b11, 2'b11, 6'd4,16'd1,16'd2,  6'd3,16'd7,16'd5},  // R9 both units
    '{1'b0,1'b0,6'd0, 6'd0,1'b0,16'd0,  6'd0,1'b0,16'd0,  1'b0,6'd0,16'd0,  2'b00, 2'b00, 6'd0,16'd0,16'd0,  6'd0,16'd0,16'd0}   // R9 drained
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 0; disp_unit = 0; disp_op = 0; disp_dst = 0;
    disp_tag_a = 0; disp_rdy_a = 0; disp_val_a = 0;
    disp_tag_b = 0; disp_rdy_b = 0; disp_val_b = 0;
    bc_valid = 0; bc_tag = 0; bc_data = 0;
    flush_valid = 0; flush_tag = 0; iss_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    #1;
    check("R1 reset disp_ready", disp_ready, 1);
    check("R1 reset iss_valid", iss_valid, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      disp_valid = TBL[v].dv; disp_unit = TBL[v].du; disp_dst = TBL[v].dst;
      disp_op = TBL[v].dst[OW-1:0];
      disp_tag_a = TBL[v].ta; disp_rdy_a = TBL[v].va; disp_val_a = TBL[v].da;
      disp_tag_b = TBL[v].tb; disp_rdy_b = TBL[v].vb; disp_val_b = TBL[v].db;
      bc_valid = TBL[v].bv; bc_tag = TBL[v].bt; bc_data = TBL[v].bd;
      iss_ready = TBL[v].rdy;
      #1;
      check($sformatf("R2 row %0d valid", v), iss_valid, TBL[v].eiv);
      if (TBL[v].eiv[0]) begin
        check($sformatf("R5 row %0d dst0", v), iss_dst[0], TBL[v].e0d);
        check($sformatf("R3 row %0d a0", v), iss_val_a[0], TBL[v].e0a);
        check($sformatf("R3 row %0d b0", v), iss_val_b[0], TBL[v].e0b);
        check($sformatf("R2 row %0d op0", v), iss_op[0], TBL[v].e0d[OW-1:0]);
      end
      if (TBL[v].eiv[1]) begin
        check($sformatf("R9 row %0d dst1", v), iss_dst[1], TBL[v].e1d);
        check($sformatf("R4 row %0d a1", v), iss_val_a[1], TBL[v].e1a);
        check($sformatf("R4 row %0d b1", v), iss_val_b[1], TBL[v].e1b);
      end
    end

    // fill the pool: dst 10..29, operand B waits on tag 50
    do_reset();
    for (int i = 0; i < ENT; i++) begin
      @(negedge clk);
      disp_valid = 1; disp_unit = 0; disp_dst = TW'(10 + i); disp_op = OW'(i);
      disp_rdy_a = 1; disp_val_a = DW'(i);
      disp_rdy_b = 0; disp_tag_b = 6'd50;
    end
    @(negedge clk);
    disp_dst = 6'd63;        // offered while full: must not be stored
    #1;
    check("R1 full disp_ready", disp_ready, 0);
    @(negedge clk);
    disp_valid = 0;
    flush_valid = 1; flush_tag = 6'd19;
    #1;
    check("R3 none ready before bcast", iss_valid, 0);
    @(negedge clk);
    flush_valid = 0;
    #1;
    check("R7 flush frees slots", disp_ready, 1);
    bc_valid = 1; bc_tag = 6'd50; bc_data = 16'd3;
    @(negedge clk);
    bc_valid = 0;
    iss_ready = 2'b01;
    for (int k = 0; k < 10; k++) begin
      #1;
      check("R5 age order valid", iss_valid[0], 1);
      check("R5 age order dst", iss_dst[0], 10 + k);
      check("R3 bcast to all a", iss_val_a[0], k);
      check("R3 bcast to all b", iss_val_b[0], 3);
      @(negedge clk);
    end
    #1;
    check("R7 flushed never offered", iss_valid, 0);

    // dispatch in a flush cycle with a younger tag is dropped
    @(negedge clk);
    iss_ready = 0;
    disp_valid = 1; disp_unit = 1; disp_dst = 6'd40;
    disp_rdy_a = 1; disp_rdy_b = 1;
    flush_valid = 1; flush_tag = 6'd0;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R7 dispatch dropped", iss_valid, 0);
    check("R7 slot still free", disp_ready, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule